// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This block sits between a 32-bit register datapath and a byte-addressed data memory whose port is one word wide. On each request it adds a sign-extended 16-bit displacement to a base register value to form the effective address. It then checks that the address suits the access size and turns the request into a word-addressed memory access.

For stores, it raises the byte enables of the lanes being written and places the low bytes of the source operand in those lanes. For loads, it waits for the word that the memory returns one cycle after the access and takes the addressed byte, halfword or whole word out of it. It then sign-extends or zero-extends that value to 32 bits.

A static input picks big-endian or little-endian numbering of the bytes within a word. A misaligned request is reported with a one-cycle flag and never reaches the memory.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is `base_val` plus `offset` sign-extended to 32 bits. The first clock edge after a request puts bits [31:2] of that address on `mem_addr`, with `mem_req` high.
- R2: A byte access is always aligned. A halfword access needs address bit 0 to be clear, and a word access needs bits [1:0] to be clear. A misaligned request raises `misalign` for exactly one cycle. In that cycle `mem_req`, `mem_we` and `mem_be` stay low, and no `ld_valid` follows.
- R3: `req_size` encodes 00 as byte, 01 as halfword and 10 as word. Enable bit i of `mem_be` covers `mem_wdata`/`mem_rdata` bits [8i+7:8i]. With `big_endian` low, byte offset k (address bits [1:0]) is lane k. With `big_endian` high, it is lane 3-k. An aligned store enables exactly the lanes of the bytes it writes.
- R4: A byte store places source bits [7:0] in its lane. A halfword store places source bits [15:0] so that the more significant byte sits at the lower byte offset in big-endian mode and at the higher byte offset in little-endian mode.
- R5: A load takes its bytes from the returned word using the same lane numbering as R3. For a halfword, the more significant byte is the one at the lower offset in big-endian mode, and the one at the higher offset in little-endian mode.
- R6: A signed (`req_unsigned` low) byte or halfword load copies the top bit of the loaded value into every higher bit of `ld_data`.
- R7: An unsigned byte or halfword load fills every higher bit of `ld_data` with zeros.
- R8: A word store drives all four enables with `mem_wdata` equal to the source operand. A word load returns the memory word unchanged, in either byte order.
- R9: The memory returns `mem_rdata` in the cycle after it sees `mem_req`. `ld_valid` is high for one cycle, two edges after `mem_req` was presented, and `ld_data` holds the aligned result in that cycle.
- R10: While and after synchronous reset, `mem_req`, `mem_we`, `mem_be`, `misalign`, `ld_valid` and `ld_data` are all zero until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Static byte order select: 1 = byte offset 0 is the most significant lane |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_unsigned | input | 1 | Zero-extend sub-word load results |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Source register for stores |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 30 | Word address (effective address bits [31:2]) |
| mem_be | output | 4 | Byte lane write enables |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Word read from memory, valid the cycle after mem_req |
| misalign | output | 1 | One-cycle misaligned access flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Aligned and extended load result |

## Verification
Assertions check on every cycle that a misaligned request stays off the memory port and that store enables form a byte, halfword or word pattern. They also check that every load result follows an issued read by two cycles, that unsigned byte results carry zero upper bits, and that the port is quiet after reset. Only the bench's sweeps can show that the chosen lanes match the selected byte order, and that sign and zero extension pick the correct bit. The sweeps cover every offset, size, signedness and byte order for both loads and stores, and include positive and negative displacements. They are also the only way to confirm that the effective address carries across the 16-bit boundary correctly.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  // Number of bytes moved by an access of the given size code (code 11 acts as word).
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int NB     = 4,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic [ADDR_W-1:0] base_val,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        size,
  input  logic              big_endian,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              misaligned,
  output logic [LANE_W-1:0] lane_lo
);

  logic [ADDR_W-1:0] off_ext;
  logic [LANE_W-1:0] byte_off;
  logic [LANE_W:0]   nbytes;
  logic [LANE_W:0]   be_base;

  always_comb begin
    off_ext  = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
    eff_addr = base_val + off_ext;
    byte_off = eff_addr[LANE_W-1:0];
    nbytes   = (LANE_W+1)'(size_bytes(size));
    // Natural alignment: low address bits under the access size must be zero.
    misaligned = |(byte_off & LANE_W'(nbytes - 1'b1));
    // Lowest lane touched: little-endian maps offset k to lane k; big-endian mirrors.
    be_base = (LANE_W+1)'(NB) - nbytes - {1'b0, byte_off};
    lane_lo = big_endian ? be_base[LANE_W-1:0] : byte_off;
  end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic [1:0]        size,
  input  logic [LANE_W-1:0] lane_lo,
  input  logic [DATA_W-1:0] src,
  output logic [NB-1:0]     be,
  output logic [DATA_W-1:0] wdata
);

  logic [LANE_W:0] nbytes;
  assign nbytes = (LANE_W+1)'(size_bytes(size));

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [LANE_W-1:0] rel;
    // Lane i holds source byte (i - lane_lo); lanes outside the access carry a
    // rotated copy that the enables leave unwritten.
    assign rel                = LANE_W'(i) - lane_lo;
    assign be[i]              = ({1'b0, rel} < nbytes) && (LANE_W'(i) >= lane_lo);
    assign wdata[8*i +: 8]    = src[8*rel +: 8];
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic [1:0]        size,
  input  logic              zero_ext,
  input  logic [LANE_W-1:0] lane_lo,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] shifted;
  logic [LANE_W:0]   nbytes;
  logic              top_bit;
  logic              fill;

  always_comb begin
    shifted = rdata >> {lane_lo, 3'b000};
    nbytes  = (LANE_W+1)'(size_bytes(size));
    top_bit = shifted[8*32'(nbytes) - 1];
    fill    = ~zero_ext & top_bit;
  end

  for (genvar k = 0; k < NB; k++) begin : g_out
    assign result[8*k +: 8] = ((LANE_W+1)'(k) < nbytes) ? shifted[8*k +: 8] : {8{fill}};
  end

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = $clog2(NB),
  localparam int WA_W   = ADDR_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_endian,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] store_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [NB-1:0]     mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              misalign,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);

  logic [ADDR_W-1:0] eff_addr;
  logic              bad_align;
  logic [LANE_W-1:0] lane_lo;
  logic [NB-1:0]     st_be;
  logic [DATA_W-1:0] st_wdata;
  logic [DATA_W-1:0] ld_aligned;

  lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NB(NB)) u_addr (
    .base_val  (base_val),
    .offset    (offset),
    .size      (req_size),
    .big_endian(big_endian),
    .eff_addr  (eff_addr),
    .misaligned(bad_align),
    .lane_lo   (lane_lo)
  );

  lsu_store_lanes #(.DATA_W(DATA_W)) u_store (
    .size   (req_size),
    .lane_lo(lane_lo),
    .src    (store_data),
    .be     (st_be),
    .wdata  (st_wdata)
  );

  // Issue stage: registered memory port plus the load context that travels along.
  logic              s1_load;
  logic [1:0]        s1_size;
  logic              s1_zext;
  logic [LANE_W-1:0] s1_lane;
  logic              go;
  assign go = req_valid & ~bad_align;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      misalign  <= 1'b0;
      s1_load   <= 1'b0;
      s1_size   <= SZ_BYTE;
      s1_zext   <= 1'b0;
      s1_lane   <= '0;
    end else begin
      mem_req   <= go;
      mem_we    <= go & req_store;
      mem_addr  <= eff_addr[ADDR_W-1:LANE_W];
      mem_be    <= (go & req_store) ? st_be : '0;
      mem_wdata <= st_wdata;
      misalign  <= req_valid & bad_align;
      s1_load   <= go & ~req_store;
      s1_size   <= req_size;
      s1_zext   <= req_unsigned;
      s1_lane   <= lane_lo;
    end
  end

  // Return stage: context lines up with the word the memory drives this cycle.
  logic              s2_load;
  logic [1:0]        s2_size;
  logic              s2_zext;
  logic [LANE_W-1:0] s2_lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_load <= 1'b0;
      s2_size <= SZ_BYTE;
      s2_zext <= 1'b0;
      s2_lane <= '0;
    end else begin
      s2_load <= s1_load;
      s2_size <= s1_size;
      s2_zext <= s1_zext;
      s2_lane <= s1_lane;
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W)) u_load (
    .size    (s2_size),
    .zero_ext(s2_zext),
    .lane_lo (s2_lane),
    .rdata   (mem_rdata),
    .result  (ld_aligned)
  );

  logic ld_zbyte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid   <= 1'b0;
      ld_data    <= '0;
      ld_zbyte_q <= 1'b0;
    end else begin
      ld_valid   <= s2_load;
      ld_data    <= s2_load ? ld_aligned : '0;
      ld_zbyte_q <= s2_load & s2_zext & (s2_size == SZ_BYTE);
    end
  end

  // R2
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (!mem_req && !mem_we && mem_be == '0));

  // R3
  store_be_shape_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || mem_be == '1));

  // R9
  ld_latency_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(mem_req && !mem_we, 2));

  // R7
  zext_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_zbyte_q) |-> (ld_data[DATA_W-1:8] == '0));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!mem_req && !mem_we && !misalign && !ld_valid && mem_be == '0));

endmodule

// File: tb/tb_lsu_lane_align.sv
module tb_lsu_lane_align;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_endian = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_unsigned = 1'b0;
  logic [31:0] base_val = '0;
  logic [15:0] offset = '0;
  logic [31:0] store_data = '0;
  logic        mem_req, mem_we, misalign, ld_valid;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, ld_data;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lsu_lane_align dut (
    .clk(clk), .rst(rst), .big_endian(big_endian), .req_valid(req_valid),
    .req_store(req_store), .req_size(req_size), .req_unsigned(req_unsigned),
    .base_val(base_val), .offset(offset), .store_data(store_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .misalign(misalign),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // Read-only memory model: byte in lane L of word w follows a fixed formula.
  function automatic logic [7:0] pat_byte(input int w, input int lane);
    return 8'(((w * 4 + lane) * 59 + 71) & 255);
  endfunction

  function automatic logic [31:0] pat_word(input int w);
    return {pat_byte(w, 3), pat_byte(w, 2), pat_byte(w, 1), pat_byte(w, 0)};
  endfunction

  always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= pat_word(int'(mem_addr[1:0]));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bytes moved and lowest lane per the requirement's numbering rule.
  function automatic int nbytes_of(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  task automatic run(input bit st, input int sz, input bit un, input int ea, input bit pos,
                     input logic [31:0] sdata);
    int nb = nbytes_of(sz);
    int k = ea & 3;
    bit bad = (k % nb) != 0;
    int lo = big_endian ? (4 - nb - k) : k;
    logic [31:0] full = 32'h0001_0000 + 32'(ea);
    logic [31:0] b = pos ? full - 32'd300 : full + 32'h0000_7F00;
    logic [15:0] o = pos ? 16'd300 : 16'h8100;
    @(negedge clk);
    req_valid = 1; req_store = st; req_size = 2'(sz); req_unsigned = un;
    base_val = b; offset = o; store_data = sdata;
    @(negedge clk);
    req_valid = 0;
    check(misalign == bad, "R2 misalign flag", {31'b0, misalign}, {31'b0, bad});
    if (bad) begin
      check(!mem_req && !mem_we && mem_be == 0, "R2 port quiet", {26'b0, mem_req, mem_we, mem_be}, 0);
    end else begin
      check(mem_req && mem_addr == full[31:2], "R1 address", {2'b0, mem_addr}, {2'b0, full[31:2]});
      if (st) begin
        logic [3:0] exp_be = 4'(((1 << nb) - 1) << lo);
        logic [31:0] msk = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 1);
        logic [31:0] got = (mem_wdata >> (8 * lo)) & msk;
        check(mem_we && mem_be == exp_be, "R3 byte enables", {28'b0, mem_be}, {28'b0, exp_be});
        if (sz == 2) check(got == sdata, "R8 word store", got, sdata);
        else check(got == (sdata & msk), "R4 store lanes", got, sdata & msk);
      end
    end
    @(negedge clk);
    check(!ld_valid, "R9 no early result", {31'b0, ld_valid}, 0);
    @(negedge clk);
    if (st || bad) begin
      check(!ld_valid, "R2 no load result", {31'b0, ld_valid}, 0);
    end else begin
      logic [31:0] w = pat_word(int'(full[3:2]));
      logic [31:0] sh = w >> (8 * lo);
      logic [31:0] exp;
      if (nb == 4) exp = w;
      else if (nb == 2) exp = un ? {16'b0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
      else exp = un ? {24'b0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
      check(ld_valid, "R9 result valid", {31'b0, ld_valid}, 1);
      if (nb == 4) check(ld_data == exp, "R8 word load", ld_data, exp);
      else if (un) check(ld_data == exp, "R7 R5 unsigned load", ld_data, exp);
      else check(ld_data == exp, "R6 R5 signed load", ld_data, exp);
    end
    @(negedge clk);
    check(!ld_valid && !misalign, "R9 single pulse", {30'b0, ld_valid, misalign}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!mem_req && !mem_we && mem_be == 0 && !misalign && !ld_valid && ld_data == 0,
          "R10 reset outputs", {25'b0, mem_req, mem_we, mem_be, misalign}, 0);
    rst = 0;
    @(negedge clk);
    check(!mem_req && !ld_valid, "R10 idle after reset", {30'b0, mem_req, ld_valid}, 0);
    for (int e = 0; e < 2; e++) begin
      big_endian = e[0];
      for (int sz = 0; sz < 3; sz++)
        for (int un = 0; un < 2; un++)
          for (int ea = 0; ea < 16; ea++)
            run(0, sz, un[0], ea, ea[0] ^ un[0], 32'h0);
      for (int sz = 0; sz < 3; sz++)
        for (int ea = 0; ea < 16; ea++)
          run(1, sz, 0, ea, ea[1], 32'h8000_0000 ^ (32'(ea) * 32'h1357_9BDF) ^ 32'(sz * 77));
    end
    // Byte order example: word 0x01234567, offset 0 selects 0x01 (big) or 0x67 (little).
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule